// File: doc/BRIEF.md
# TDM Switch Host Access Decoder

This block sits between a simple synchronous host bus and the storage of a four-stream, 32-channel time-slot switch. The host sees a 64-byte address space. Half of it reaches an 8-bit control register. The other half is a 32-byte window into one of three memories: the received-sample data memory, the low connection memory, or the high connection memory. Fields of the control register choose both the memory and the stream section that the window exposes.

The control register also carries a split mode. In split mode, host reads come from the data memory and host writes go to the low connection memory, whatever the memory-select field says. This lets software watch incoming samples while it programs connections. The processor-enable bit of the register is exported to the switching datapath.

The block drives one shared address and write-data bus and per-memory enables toward the three arrays. It expects each array to return read data combinationally for the address it drives. It registers the selected read data, so read data appears one cycle after the strobe.

Top module: `tsw_host_access`

## Requirements
- R1: After reset the control register is 0x00, proc_en_o is 0 and rdata_o is 0x00.
- R2: An access with addr_i[5]=0 reaches the control register, and addr_i[4:0] has no effect on it. A write stores wdata_i with bits 5 and 2 forced to 0. A read returns the stored value.
- R3: With addr_i[5]=1, mem_addr_o equals {control[1:0], addr_i[4:0]}: the stream in the top two bits and the channel in the low five.
- R4: With control bit 7 = 0, control bits 4..3 choose the memory for both reads and writes. The code 01 selects the data memory, 10 the low connection memory and 11 the high connection memory.
- R5: The data memory is never written from the host. A write issued while it is selected changes no memory and leaves the later read-back unchanged.
- R6: With control bit 7 = 1, every windowed read comes from the data memory and every windowed write goes to the low connection memory, whatever bits 4..3 hold. This lasts until the control register is rewritten.
- R7: On the high connection memory, only bits 2 and 0 count. The write data sent to it has all other bits cleared, and a read of it returns all other bits as 0, whatever the array holds.
- R8: With select code 00 and split mode off, a windowed read returns 0x00 and a windowed write reaches no memory.
- R9: proc_en_o equals control bit 6. It changes on the clock edge that writes the control register.
- R10: rdata_o updates on the clock edge that ends a read-strobe cycle and holds its value while no read is strobed.
- R11: A control-register access asserts no memory read or write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Host address; bit 5 selects the memory window |
| wdata_i | input | 8 | Host write data |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| rdata_o | output | 8 | Registered host read data |
| proc_en_o | output | 1 | Processor-enable bit toward the switching datapath |
| mem_addr_o | output | 7 | Shared memory address {stream, channel} |
| mem_wdata_o | output | 8 | Shared memory write data, masked for the high connection memory |
| dm_rd_o | output | 1 | Data memory read enable |
| dm_rdata_i | input | 8 | Data memory read data |
| cml_rd_o | output | 1 | Low connection memory read enable |
| cml_wr_o | output | 1 | Low connection memory write enable |
| cml_rdata_i | input | 8 | Low connection memory read data |
| cmh_rd_o | output | 1 | High connection memory read enable |
| cmh_wr_o | output | 1 | High connection memory write enable |
| cmh_rdata_i | input | 8 | High connection memory read data |

## Verification
The bench builds the block with its default parameters: two stream bits and five channel bits. This gives four stream sections of 32 channels. Its 128-entry memory models can therefore be checked at exact locations such as stream 2, channel 19, and a write to one stream can be shown to leave the same channel of another stream untouched. The high connection model is preloaded with all ones, and the other two models with distinct patterns. This makes the read mask, ignored writes and the empty select code visible at rdata_o.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  // control register layout (fields decoded by the datapath keep fixed positions)
  localparam int unsigned CR_SPLIT  = 7;
  localparam int unsigned CR_PROC   = 6;
  localparam int unsigned CR_SEL_HI = 4;
  localparam int unsigned CR_SEL_LO = 3;
  localparam logic [7:0]  CR_KEEP   = 8'hDB;
  localparam logic [7:0]  CMH_KEEP  = 8'h05;

  localparam logic [1:0] SEL_NONE = 2'b00;
  localparam logic [1:0] SEL_DM   = 2'b01;
  localparam logic [1:0] SEL_CML  = 2'b10;
  localparam logic [1:0] SEL_CMH  = 2'b11;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_CTRL,
    TGT_DM,
    TGT_CML,
    TGT_CMH
  } tgt_e;
endpackage

// File: rtl/tsw_ctrl_reg.sv
module tsw_ctrl_reg
  import tsw_pkg::*;
#(
  parameter int unsigned STREAM_W = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          ctrl_o,
  output logic                split_o,
  output logic                proc_en_o,
  output logic [1:0]          sel_o,
  output logic [STREAM_W-1:0] stream_o
);
  logic [7:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (wr_i) ctrl_q <= wdata_i & CR_KEEP;
  end

  assign ctrl_o    = ctrl_q;
  assign split_o   = ctrl_q[CR_SPLIT];
  assign proc_en_o = ctrl_q[CR_PROC];
  assign sel_o     = ctrl_q[CR_SEL_HI:CR_SEL_LO];
  assign stream_o  = ctrl_q[STREAM_W-1:0];

  // R9
  proc_en_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> proc_en_o == $past(wdata_i[CR_PROC]));

  // R2
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_o));
endmodule

// File: rtl/tsw_route.sv
module tsw_route
  import tsw_pkg::*;
#(
  parameter int unsigned STREAM_W = 2,
  parameter int unsigned CHAN_W   = 5,
  localparam int unsigned ADDR_W  = CHAN_W + 1,
  localparam int unsigned MEM_AW  = STREAM_W + CHAN_W
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [7:0]          wdata_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic                split_i,
  input  logic [1:0]          sel_i,
  input  logic [STREAM_W-1:0] stream_i,
  output logic                ctrl_wr_o,
  output tgt_e                rd_tgt_o,
  output logic [MEM_AW-1:0]   mem_addr_o,
  output logic [7:0]          mem_wdata_o,
  output logic                dm_rd_o,
  output logic                cml_rd_o,
  output logic                cml_wr_o,
  output logic                cmh_rd_o,
  output logic                cmh_wr_o
);
  logic mem_hit;
  tgt_e wr_tgt;

  assign mem_hit = addr_i[ADDR_W-1];

  always_comb begin
    if (!mem_hit)     rd_tgt_o = TGT_CTRL;
    else if (split_i) rd_tgt_o = TGT_DM;
    else begin
      case (sel_i)
        SEL_DM:  rd_tgt_o = TGT_DM;
        SEL_CML: rd_tgt_o = TGT_CML;
        SEL_CMH: rd_tgt_o = TGT_CMH;
        default: rd_tgt_o = TGT_NONE;
      endcase
    end
  end

  // data memory is read-only from the host: no write target for it
  always_comb begin
    if (!mem_hit)     wr_tgt = TGT_CTRL;
    else if (split_i) wr_tgt = TGT_CML;
    else begin
      case (sel_i)
        SEL_CML: wr_tgt = TGT_CML;
        SEL_CMH: wr_tgt = TGT_CMH;
        default: wr_tgt = TGT_NONE;
      endcase
    end
  end

  assign mem_addr_o  = {stream_i, addr_i[CHAN_W-1:0]};
  assign mem_wdata_o = (wr_tgt == TGT_CMH) ? (wdata_i & CMH_KEEP) : wdata_i;

  assign ctrl_wr_o = wr_i && (wr_tgt == TGT_CTRL);
  assign dm_rd_o   = rd_i && (rd_tgt_o == TGT_DM);
  assign cml_rd_o  = rd_i && (rd_tgt_o == TGT_CML);
  assign cmh_rd_o  = rd_i && (rd_tgt_o == TGT_CMH);
  assign cml_wr_o  = wr_i && (wr_tgt == TGT_CML);
  assign cmh_wr_o  = wr_i && (wr_tgt == TGT_CMH);
endmodule

// File: rtl/tsw_rdata.sv
module tsw_rdata
  import tsw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  tgt_e       rd_tgt_i,
  input  logic [7:0] ctrl_i,
  input  logic [7:0] dm_rdata_i,
  input  logic [7:0] cml_rdata_i,
  input  logic [7:0] cmh_rdata_i,
  output logic [7:0] rdata_o
);
  logic [7:0] rdata_d, rdata_q;

  always_comb begin
    case (rd_tgt_i)
      TGT_CTRL: rdata_d = ctrl_i;
      TGT_DM:   rdata_d = dm_rdata_i;
      TGT_CML:  rdata_d = cml_rdata_i;
      TGT_CMH:  rdata_d = cmh_rdata_i & CMH_KEEP;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  // R7
  cmh_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rd_tgt_i == TGT_CMH) |=> (rdata_o & ~CMH_KEEP) == 8'h00);

  // R8
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rd_tgt_i == TGT_NONE) |=> rdata_o == 8'h00);
endmodule

// File: rtl/tsw_host_access.sv
module tsw_host_access
  import tsw_pkg::*;
#(
  parameter int unsigned STREAM_W = 2,
  parameter int unsigned CHAN_W   = 5,
  localparam int unsigned ADDR_W  = CHAN_W + 1,
  localparam int unsigned MEM_AW  = STREAM_W + CHAN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [7:0]        rdata_o,
  output logic              proc_en_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              dm_rd_o,
  input  logic [7:0]        dm_rdata_i,
  output logic              cml_rd_o,
  output logic              cml_wr_o,
  input  logic [7:0]        cml_rdata_i,
  output logic              cmh_rd_o,
  output logic              cmh_wr_o,
  input  logic [7:0]        cmh_rdata_i
);
  logic [7:0]          ctrl;
  logic                split;
  logic [1:0]          sel;
  logic [STREAM_W-1:0] stream;
  logic                ctrl_wr;
  tgt_e                rd_tgt;

  tsw_ctrl_reg #(.STREAM_W(STREAM_W)) i_ctrl_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ctrl_wr),
    .wdata_i   (wdata_i),
    .ctrl_o    (ctrl),
    .split_o   (split),
    .proc_en_o (proc_en_o),
    .sel_o     (sel),
    .stream_o  (stream)
  );

  tsw_route #(.STREAM_W(STREAM_W), .CHAN_W(CHAN_W)) i_route (
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .split_i     (split),
    .sel_i       (sel),
    .stream_i    (stream),
    .ctrl_wr_o   (ctrl_wr),
    .rd_tgt_o    (rd_tgt),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .dm_rd_o     (dm_rd_o),
    .cml_rd_o    (cml_rd_o),
    .cml_wr_o    (cml_wr_o),
    .cmh_rd_o    (cmh_rd_o),
    .cmh_wr_o    (cmh_wr_o)
  );

  tsw_rdata i_rdata (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (rd_i),
    .rd_tgt_i    (rd_tgt),
    .ctrl_i      (ctrl),
    .dm_rdata_i  (dm_rdata_i),
    .cml_rdata_i (cml_rdata_i),
    .cmh_rdata_i (cmh_rdata_i),
    .rdata_o     (rdata_o)
  );

  // R11
  ctrl_no_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i[ADDR_W-1] |-> !(dm_rd_o || cml_rd_o || cmh_rd_o || cml_wr_o || cmh_wr_o));

  // R4
  one_reader_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dm_rd_o, cml_rd_o, cmh_rd_o}));

  // R6
  split_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proc_en_o || !proc_en_o) && addr_i[ADDR_W-1] && wr_i && split |-> cml_wr_o && !cmh_wr_o);

  // R5
  dm_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!split && sel == SEL_DM) |-> !(cml_wr_o || cmh_wr_o));

  // R7
  cmh_wdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmh_wr_o |-> (mem_wdata_o & ~CMH_KEEP) == 8'h00);
endmodule

// File: tb/test_tsw_host_access.sv
`timescale 1ns/1ps
module test_tsw_host_access;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] rdata;
  logic       proc_en;
  logic [6:0] mem_addr;
  logic [7:0] mem_wdata;
  logic       dm_rd, cml_rd, cml_wr, cmh_rd, cmh_wr;
  logic [7:0] dm_mem  [128];
  logic [7:0] cml_mem [128];
  logic [7:0] cmh_mem [128];
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  tsw_host_access i_tsw_host_access (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .rd_i(rd), .wr_i(wr), .rdata_o(rdata), .proc_en_o(proc_en),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .dm_rd_o(dm_rd), .dm_rdata_i(dm_mem[mem_addr]),
    .cml_rd_o(cml_rd), .cml_wr_o(cml_wr), .cml_rdata_i(cml_mem[mem_addr]),
    .cmh_rd_o(cmh_rd), .cmh_wr_o(cmh_wr), .cmh_rdata_i(cmh_mem[mem_addr])
  );

  initial begin
    for (int i = 0; i < 128; i++) begin
      dm_mem[i]  = 8'(i) ^ 8'h5A;
      cml_mem[i] = 8'hC3;
      cmh_mem[i] = 8'hFF;
    end
  end

  always @(posedge clk) begin
    if (cml_wr) cml_mem[mem_addr] <= mem_wdata;
    if (cmh_wr) cmh_mem[mem_addr] <= mem_wdata;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 rdata", rdata, 8'h00);
    check("R1 proc_en", {7'd0, proc_en}, 8'h00);
    bus_rd(6'h00, d);
    check("R1 ctrl", d, 8'h00);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    bus_wr(6'h15, 8'hFF);
    check("R9 proc_en set", {7'd0, proc_en}, 8'h01);
    bus_rd(6'h0A, d);
    check("R2 ctrl readback masked", d, 8'hDB);
    bus_wr(6'h1F, 8'h00);
    check("R9 proc_en clear", {7'd0, proc_en}, 8'h00);
    bus_rd(6'h00, d);
    check("R2 ctrl cleared", d, 8'h00);
  endtask

  task automatic t_window();
    logic [7:0] d;
    bus_wr(6'h00, 8'h12);
    check("R11 ctrl wr no mem", {7'd0, cml_wr | cmh_wr}, 8'h00);
    bus_wr(6'h33, 8'hA7);
    check("R3 stream2 ch19", cml_mem[83], 8'hA7);
    bus_rd(6'h33, d);
    check("R4 cml readback", d, 8'hA7);
    bus_wr(6'h00, 8'h11);
    bus_wr(6'h33, 8'h3C);
    check("R3 stream1 ch19", cml_mem[51], 8'h3C);
    check("R3 stream2 untouched", cml_mem[83], 8'hA7);
  endtask

  task automatic t_select();
    logic [7:0] d;
    bus_wr(6'h00, 8'h08);
    bus_rd(6'h25, d);
    check("R4 dm read", d, 8'h5F);
    bus_wr(6'h00, 8'h19);
    bus_rd(6'h28, d);
    check("R7 cmh read mask", d, 8'h05);
    bus_wr(6'h27, 8'hFA);
    check("R7 cmh write mask", cmh_mem[39], 8'h00);
    bus_wr(6'h27, 8'hFF);
    check("R4 cmh write", cmh_mem[39], 8'h05);
  endtask

  task automatic t_dm_ro();
    logic [7:0] d;
    bus_wr(6'h00, 8'h08);
    bus_wr(6'h25, 8'h00);
    bus_rd(6'h25, d);
    check("R5 dm unchanged", d, 8'h5F);
    check("R5 cml untouched", cml_mem[5], 8'hC3);
    check("R5 cmh untouched", cmh_mem[5], 8'hFF);
  endtask

  task automatic t_split();
    logic [7:0] d;
    bus_wr(6'h00, 8'h98);
    bus_wr(6'h21, 8'h6E);
    check("R6 write to cml", cml_mem[1], 8'h6E);
    check("R6 cmh untouched", cmh_mem[1], 8'hFF);
    bus_rd(6'h21, d);
    check("R6 read from dm", d, 8'h5B);
    bus_wr(6'h00, 8'h10);
    bus_rd(6'h21, d);
    check("R6 split ended", d, 8'h6E);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    bus_wr(6'h00, 8'h00);
    bus_wr(6'h22, 8'h11);
    bus_rd(6'h22, d);
    check("R8 read zero", d, 8'h00);
    bus_wr(6'h00, 8'h10);
    bus_rd(6'h22, d);
    check("R8 write ignored", d, 8'hC3);
  endtask

  task automatic t_latency();
    logic [7:0] d;
    bus_wr(6'h00, 8'h08);
    bus_rd(6'h25, d);
    @(negedge clk); addr = 6'h21; rd = 1'b1;
    #1;
    check("R10 before edge", rdata, 8'h5F);
    @(negedge clk); rd = 1'b0;
    check("R10 after edge", rdata, 8'h5B);
    addr = 6'h25;
    repeat (3) @(negedge clk);
    check("R10 hold", rdata, 8'h5B);
  endtask

  initial begin
    #20 rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_window();
    t_select();
    t_dm_ro();
    t_split();
    t_reserved();
    t_latency();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule